// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Nibble Codec

This block protects a 4-bit value with an 8-bit codeword. The encoder side turns a data nibble into a codeword made of three group parity bits, the four data bits and one parity bit over the whole word. The checker side takes a received 8-bit word. It returns the data nibble after any correction, the 3-bit syndrome, and four mutually exclusive status flags: clean word, single error corrected, uncorrectable double error, and error confined to the overall parity bit.

Codeword positions are counted from 1 at the most significant end. The group parity bits sit at the power-of-two positions, so a nonzero syndrome is the position of a single flipped bit. The overall parity bit separates a single flip from a double flip. Both paths are combinational. A parameter can add one output register stage to each path for timing closure.

Top module: `secded84_codec`

## Requirements
- R1: Codeword bit 7 is position 1 and bit 0 is position 8. Positions 1 to 7 hold, in order, parity A, parity B, data bit 3, parity C, data bit 2, data bit 1 and data bit 0 of the input nibble. Position 8 holds the overall parity bit.
- R2: Parity A gives even parity over positions {1,3,5,7}. Parity B does so over {2,3,6,7} and parity C over {4,5,6,7}. The overall bit makes the full 8-bit codeword even.
- R3: Syndrome bit 0, bit 1 and bit 2 are the XOR of the received positions {1,3,5,7}, {2,3,6,7} and {4,5,6,7}. For a single flip in positions 1 to 7 the syndrome equals that position.
- R4: A zero syndrome with even overall parity raises only the clean flag, and the data output equals the received data positions.
- R5: A nonzero syndrome with odd overall parity raises only the corrected flag. The bit at the position named by the syndrome is inverted before the data is extracted.
- R6: A nonzero syndrome with even overall parity raises only the double-error flag. The data output is the received data positions, not corrected.
- R7: A zero syndrome with odd overall parity raises only the overall-parity-error flag. The data output equals the received data positions.
- R8: Exactly one of the four status flags is high at all times.
- R9: With OUT_REG=1 every output follows its input one clock later. During reset the outputs show a codeword of 0 and a data output of 0 with a zero syndrome and only the clean flag high. With OUT_REG=0 the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 4 | Nibble to encode |
| enc_code_o | output | 8 | Codeword, bit 7 is position 1 |
| chk_word_i | input | 8 | Received word, bit 7 is position 1 |
| chk_data_o | output | 4 | Data after correction |
| chk_syndrome_o | output | 3 | Syndrome, bit 2 is the top group |
| chk_clean_o | output | 1 | No error found |
| chk_fixed_o | output | 1 | Single error corrected |
| chk_double_o | output | 1 | Uncorrectable double error |
| chk_ovp_o | output | 1 | Error in the overall parity bit only |

## Verification
On every cycle the assertions check that the checker raises exactly one flag. They also check that the clean, double-error and parity-bit-error outcomes pass the received data through unchanged, and that a correction alters at most one data bit. They check that the output stage repeats its input one cycle later. Only the bench's scenarios can show that the codeword layout, the syndrome-to-position mapping and the corrected data are right. It does this by sweeping all 16 nibbles through the encoder, then through every single flip and every pair of flips across the eight positions.

// File: rtl/secded84_pkg.sv
package secded84_pkg;

   localparam int SYN_W  = 3;
   localparam int CODE_W = 2 ** SYN_W;
   localparam int DATA_W = CODE_W - SYN_W - 1;
   localparam int LAST_P = CODE_W - 1;

   typedef struct packed {
      logic clean;
      logic fixed;
      logic dbl;
      logic ovp;
   } chk_status_t;

   localparam int STAT_W = $bits(chk_status_t);

   // Mask of the codeword bits covered by syndrome group g.
   function automatic logic [CODE_W-1:0] group_mask(input int g, input bit incl_par);
      logic [CODE_W-1:0] m;
      m = '0;
      for (int p = 1; p <= LAST_P; p++) begin
         if (((p >> g) & 1) == 1 && (incl_par || p != (1 << g)))
            m[CODE_W-p] = 1'b1;
      end
      return m;
   endfunction

   // Spreads the nibble over non-power-of-two positions, MSB first.
   function automatic logic [CODE_W-1:0] place_data(input logic [DATA_W-1:0] d);
      logic [CODE_W-1:0] w;
      int k;
      w = '0;
      k = 0;
      for (int p = 1; p <= LAST_P; p++) begin
         if ((p & (p - 1)) != 0) begin
            w[CODE_W-p] = d[DATA_W-1-k];
            k++;
         end
      end
      return w;
   endfunction

   // Gathers the data positions back into a nibble.
   function automatic logic [DATA_W-1:0] pick_data(input logic [CODE_W-1:0] w);
      logic [DATA_W-1:0] d;
      int k;
      d = '0;
      k = 0;
      for (int p = 1; p <= LAST_P; p++) begin
         if ((p & (p - 1)) != 0) begin
            d[DATA_W-1-k] = w[CODE_W-p];
            k++;
         end
      end
      return d;
   endfunction

   // One-hot mask of the position named by a syndrome value.
   function automatic logic [CODE_W-1:0] flip_mask(input logic [SYN_W-1:0] s);
      logic [CODE_W-1:0] m;
      m = '0;
      for (int p = 1; p <= LAST_P; p++) begin
         if (s == SYN_W'(p))
            m[CODE_W-p] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/secded84_enc.sv
module secded84_enc
   import secded84_pkg::*;
(
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] placed;
   logic [SYN_W-1:0]  grp_par;
   logic [CODE_W-1:0] word;

   assign placed = place_data(data_i);

   for (genvar g = 0; g < SYN_W; g++) begin : g_grp
      localparam logic [CODE_W-1:0] MASK = group_mask(g, 1'b0);
      assign grp_par[g] = ^(placed & MASK);
   end

   always_comb begin
      word = placed;
      for (int g = 0; g < SYN_W; g++)
         word[CODE_W-(1 << g)] = grp_par[g];
      word[0] = ^word[CODE_W-1:1];
   end

   assign code_o = word;

endmodule

// File: rtl/secded84_chk.sv
module secded84_chk
   import secded84_pkg::*;
(
   input  logic [CODE_W-1:0] word_i,
   output logic [DATA_W-1:0] data_o,
   output logic [SYN_W-1:0]  syn_o,
   output chk_status_t       stat_o
);

   logic [SYN_W-1:0]  syn;
   logic              odd;
   logic              syn_nz;
   logic [CODE_W-1:0] fix;

   for (genvar g = 0; g < SYN_W; g++) begin : g_syn
      localparam logic [CODE_W-1:0] MASK = group_mask(g, 1'b1);
      assign syn[g] = ^(word_i & MASK);
   end

   assign odd    = ^word_i;
   assign syn_nz = |syn;

   always_comb begin
      stat_o.clean = !syn_nz && !odd;
      stat_o.fixed =  syn_nz &&  odd;
      stat_o.dbl   =  syn_nz && !odd;
      stat_o.ovp   = !syn_nz &&  odd;
   end

   assign fix    = stat_o.fixed ? flip_mask(syn) : '0;
   assign data_o = pick_data(word_i ^ fix);
   assign syn_o  = syn;

endmodule

// File: rtl/secded84_stage.sv
module secded84_stage #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    RST_VAL = '0,
   parameter bit              USE_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (USE_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RST_VAL;
         else        q_r <= d_i;
      end
      assign q_o = q_r;

      assert_stage_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (q_o == $past(d_i)));
   end else begin : g_wire
      assign q_o = d_i;
   end

endmodule

// File: rtl/secded84_codec.sv
module secded84_codec
   import secded84_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] enc_data_i,
   output logic [7:0] enc_code_o,
   input  logic [7:0] chk_word_i,
   output logic [3:0] chk_data_o,
   output logic [2:0] chk_syndrome_o,
   output logic       chk_clean_o,
   output logic       chk_fixed_o,
   output logic       chk_double_o,
   output logic       chk_ovp_o
);

   localparam int BUN_W = DATA_W + SYN_W + STAT_W;
   localparam logic [BUN_W-1:0] BUN_RST = {{DATA_W{1'b0}}, {SYN_W{1'b0}}, 4'b1000};

   logic [CODE_W-1:0] enc_code_c;
   logic [DATA_W-1:0] chk_data_c;
   logic [SYN_W-1:0]  chk_syn_c;
   chk_status_t       chk_stat_c;
   logic [BUN_W-1:0]  bun_c;
   logic [BUN_W-1:0]  bun_q;
   logic [DATA_W-1:0] raw_data;

   secded84_enc u_enc (
      .data_i (enc_data_i),
      .code_o (enc_code_c)
   );

   secded84_chk u_chk (
      .word_i (chk_word_i),
      .data_o (chk_data_c),
      .syn_o  (chk_syn_c),
      .stat_o (chk_stat_c)
   );

   secded84_stage #(.W(CODE_W), .RST_VAL('0), .USE_REG(OUT_REG)) u_enc_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (enc_code_c),
      .q_o   (enc_code_o)
   );

   assign bun_c = {chk_data_c, chk_syn_c, chk_stat_c};

   secded84_stage #(.W(BUN_W), .RST_VAL(BUN_RST), .USE_REG(OUT_REG)) u_chk_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bun_c),
      .q_o   (bun_q)
   );

   assign {chk_data_o, chk_syndrome_o, chk_clean_o, chk_fixed_o, chk_double_o, chk_ovp_o} = bun_q;

   assign raw_data = pick_data(chk_word_i);

   assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({chk_stat_c.clean, chk_stat_c.fixed, chk_stat_c.dbl, chk_stat_c.ovp}) == 1);

   assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chk_stat_c.clean |-> (chk_syn_c == '0 && chk_data_c == raw_data));

   assert_fix_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_stat_c.fixed |-> (chk_syn_c != '0 && $countones(chk_data_c ^ raw_data) <= 1));

   assert_double_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_stat_c.dbl |-> (chk_syn_c != '0 && chk_data_c == raw_data));

   assert_ovp_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_stat_c.ovp |-> (chk_syn_c == '0 && chk_data_c == raw_data));

endmodule

// File: tb/secded84_codec_tb_top.sv
module secded84_codec_tb_top;

   localparam time CLK_P = 8ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] enc_data_i = '0;
   logic [7:0] enc_code_o;
   logic [7:0] chk_word_i = '0;
   logic [3:0] chk_data_o;
   logic [2:0] chk_syndrome_o;
   logic       chk_clean_o, chk_fixed_o, chk_double_o, chk_ovp_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   secded84_codec #(.OUT_REG(1'b1)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .enc_data_i     (enc_data_i),
      .enc_code_o     (enc_code_o),
      .chk_word_i     (chk_word_i),
      .chk_data_o     (chk_data_o),
      .chk_syndrome_o (chk_syndrome_o),
      .chk_clean_o    (chk_clean_o),
      .chk_fixed_o    (chk_fixed_o),
      .chk_double_o   (chk_double_o),
      .chk_ovp_o      (chk_ovp_o)
   );

   // Independent model: {p1,p2,d1,p3,d2,d3,d4,p4}, d1 = nibble bit 3.
   function automatic logic [7:0] model_code(input logic [3:0] d);
      logic p1, p2, p3;
      logic [6:0] w7;
      p1 = d[3] ^ d[2] ^ d[0];
      p2 = d[3] ^ d[1] ^ d[0];
      p3 = d[2] ^ d[1] ^ d[0];
      w7 = {p1, p2, d[3], p3, d[2], d[1], d[0]};
      return {w7, ^w7};
   endfunction

   function automatic logic [3:0] model_raw(input logic [7:0] w);
      return {w[5], w[3], w[2], w[1]};
   endfunction

   function automatic logic [7:0] pos_bit(input int pos);
      return 8'h01 << (8 - pos);
   endfunction

   // Bundle {data, syndrome, clean, fixed, double, ovp}
   function automatic logic [10:0] got_chk();
      return {chk_data_o, chk_syndrome_o, chk_clean_o, chk_fixed_o, chk_double_o, chk_ovp_o};
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] d, input logic [7:0] w);
      @(negedge clk);
      enc_data_i = d;
      chk_word_i = w;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      enc_data_i = 4'hF;
      chk_word_i = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      check(enc_code_o == 8'h00, "R9 reset code", enc_code_o, 0);
      check(got_chk() == 11'b0000_000_1000, "R9 reset checker", got_chk(), 11'b0000_000_1000);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_layout();
      // nibble 1011: p1=0 p2=1 d1=1 p3=0 d2=0 d3=1 d4=1 p4=0
      apply(4'b1011, 8'h66);
      check(enc_code_o == 8'h66, "R1 layout 1011", enc_code_o, 8'h66);
      check(got_chk() == {4'b1011, 3'd0, 4'b1000}, "R4 known word", got_chk(), {4'b1011, 3'd0, 4'b1000});
   endtask

   task automatic t_encode_clean();
      for (int d = 0; d < 16; d++) begin
         logic [7:0] c;
         c = model_code(4'(d));
         apply(4'(d), c);
         check(enc_code_o == c, "R2 encode", enc_code_o, c);
         check(got_chk() == {4'(d), 3'd0, 4'b1000}, "R4 clean", got_chk(), {4'(d), 3'd0, 4'b1000});
      end
   endtask

   task automatic t_single();
      for (int d = 0; d < 16; d++) begin
         for (int p = 1; p <= 8; p++) begin
            logic [7:0]  w;
            logic [10:0] e;
            w = model_code(4'(d)) ^ pos_bit(p);
            if (p <= 7) begin
               e = {4'(d), 3'(p), 4'b0100};
               apply(4'(d), w);
               check(got_chk() == e, "R5 R3 single flip", got_chk(), e);
            end else begin
               e = {4'(d), 3'd0, 4'b0001};
               apply(4'(d), w);
               check(got_chk() == e, "R7 overall bit flip", got_chk(), e);
            end
         end
      end
   endtask

   task automatic t_double();
      for (int d = 0; d < 16; d++) begin
         for (int i = 1; i <= 8; i++) begin
            for (int j = i + 1; j <= 8; j++) begin
               logic [7:0]  w;
               logic [2:0]  s;
               logic [10:0] e;
               w = model_code(4'(d)) ^ pos_bit(i) ^ pos_bit(j);
               s = 3'(i) ^ ((j == 8) ? 3'd0 : 3'(j));
               e = {model_raw(w), s, 4'b0010};
               apply(4'(d), w);
               check(got_chk() == e, "R6 double flip", got_chk(), e);
               check(chk_clean_o + chk_fixed_o + chk_double_o + chk_ovp_o == 1,
                     "R8 one flag", 32'(chk_clean_o + chk_fixed_o + chk_double_o + chk_ovp_o), 1);
            end
         end
      end
   endtask

   task automatic t_latency();
      apply(4'h3, model_code(4'h3));
      @(negedge clk);
      enc_data_i = 4'hC;
      chk_word_i = model_code(4'hC) ^ pos_bit(6);
      #1;
      check(enc_code_o == model_code(4'h3), "R9 holds before edge", enc_code_o, model_code(4'h3));
      check(chk_data_o == 4'h3 && chk_clean_o, "R9 checker holds", chk_data_o, 4'h3);
      @(posedge clk);
      #1;
      check(enc_code_o == model_code(4'hC), "R9 updates after edge", enc_code_o, model_code(4'hC));
      check(got_chk() == {4'hC, 3'd6, 4'b0100}, "R9 R5 checker after edge", got_chk(), {4'hC, 3'd6, 4'b0100});
   endtask

   initial begin
      t_reset();
      t_layout();
      t_encode_clean();
      t_single();
      t_double();
      t_latency();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule